// File: doc/BRIEF.md
# Serial Receive Path with Level and Finish Interrupts

This block is the receive half of a serial peripheral master. The serial input is sampled on each bit-clock strobe from a shared clock-enable. The bits are shifted in most significant bit first, and every eighth bit completes a byte. In unit mode each completed byte is parked in a single receive data register. In sequential mode completed bytes are queued in a 32-entry first-in first-out store, and software drains it in groups of 16 bytes.

Two request sources are raised as sticky status flags. The level request marks a fill point: the data register being loaded, or the queue reaching 16 or 32 entries. The finish request marks the end of a transfer: the data register being loaded, or the queue becoming full. Each source has its own enable. The enabled sources are ORed into one registered receive interrupt line. A byte that arrives when there is no room for it is dropped and flagged as an overrun.

Top module: `spi_rx_ctrl`

## Requirements
- R1: While `rx_en` is high, each `bit_ce` pulse samples `sdi` into the shift buffer, most significant bit first. The eighth pulse completes a byte. When `rx_en` is low the bit counter returns to zero, so any partial byte is dropped.
- R2: With `seq_mode` low, a completed byte is loaded into the data register. `fifo_level` then reads 1, and status bit 0 (level) and status bit 1 (finish) both set. All three show on the clock edge after the one that samples the eighth bit.
- R3: With `seq_mode` high, completed bytes enter a 32-entry queue in arrival order. `fifo_level` shows the occupancy. A `rd_pop` pulse removes the oldest entry and presents it on `rd_data` from the next edge. In unit mode `rd_pop` reads the data register and empties it.
- R4: In sequential mode, status bit 0 sets when a byte is stored with no pop in the same cycle and the occupancy becomes 16 or 32. Reaching any other occupancy leaves it unchanged.
- R5: In sequential mode, status bit 1 sets only when a stored byte, with no pop in the same cycle, brings the occupancy to 32.
- R6: A byte that completes while the store is full is discarded and sets status bit 2 (overrun). The store is full when the queue holds 32 entries in sequential mode, or when the data register is unread in unit mode. The stored data and `fifo_level` stay unchanged.
- R7: Status bits are sticky. A cycle with `clr_wr` high clears each bit whose `clr_mask` bit is 1. A set in the same cycle wins over the clear.
- R8: `rx_irq` equals (status[0] AND `lvl_ie`) OR (status[1] AND `fin_ie`), registered, so it lags the status by one edge. Overrun does not drive it.
- R9: A `rd_pop` while the store is empty has no effect: `rd_data` and `fifo_level` stay unchanged.
- R10: After reset, `rd_data`, `fifo_level`, `status` and `rx_irq` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receive enable; low restarts byte framing |
| bit_ce | input | 1 | Bit-clock rising-edge strobe |
| sdi | input | 1 | Serial data input |
| seq_mode | input | 1 | 1 = sequential (queue) mode, 0 = unit mode |
| rd_pop | input | 1 | Read strobe for the data register or queue |
| rd_data | output | 8 | Last byte read |
| fifo_level | output | 6 | Stored byte count |
| clr_wr | input | 1 | Status clear strobe |
| clr_mask | input | 3 | Write-one-to-clear mask {ovr, fin, lvl} |
| lvl_ie | input | 1 | Level request enable |
| fin_ie | input | 1 | Finish request enable |
| status | output | 3 | Sticky flags {ovr, fin, lvl} |
| rx_irq | output | 1 | Combined receive interrupt |

## Verification
Unit mode is tried with isolated bytes and then with a second byte arriving before the first is read. The isolated bytes show that both requests fire together. The second byte separates overrun from overwrite. Sequential mode is filled one byte at a time through 15, 16, 31, 32 and 33 entries, which shows that the two fill points and the full-only finish request fire exactly where they should and nowhere else. A partial byte cut off by `rx_en`, pops on an empty store and masked interrupt enables show framing restart, read idling and the per-source gating.

// File: rtl/spi_rx_pkg.sv
package spi_rx_pkg;
  localparam int ST_LVL = 0;
  localparam int ST_FIN = 1;
  localparam int ST_OVR = 2;
  localparam int ST_W   = 3;

  typedef struct packed {
    logic ovr_hit;
    logic fin_hit;
    logic lvl_hit;
  } rx_evt_t;
endpackage

// File: rtl/spi_rx_shifter.sv
module spi_rx_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_en,
  input  logic              bit_ce,
  input  logic              sdi,
  output logic              byte_vld,
  output logic [DATA_W-1:0] byte_q
);
  localparam int CW = $clog2(DATA_W);

  logic [CW-1:0]     bit_cnt;
  logic [DATA_W-1:0] shreg;
  logic [DATA_W-1:0] shreg_nxt;

  assign shreg_nxt = {shreg[DATA_W-2:0], sdi};

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt  <= '0;
      shreg    <= '0;
      byte_vld <= 1'b0;
      byte_q   <= '0;
    end else begin
      byte_vld <= 1'b0;
      if (!rx_en) begin
        bit_cnt <= '0;
      end else if (bit_ce) begin
        shreg <= shreg_nxt;
        if (bit_cnt == CW'(DATA_W - 1)) begin
          bit_cnt  <= '0;
          byte_vld <= 1'b1;
          byte_q   <= shreg_nxt;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_rx_store.sv
module spi_rx_store
  import spi_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 32,
  parameter int THRESH = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int LW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              seq_mode,
  input  logic              push,
  input  logic [DATA_W-1:0] din,
  input  logic              pop,
  output logic [DATA_W-1:0] rd_data,
  output logic [LW-1:0]     level,
  output rx_evt_t           evt
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wptr, rptr;
  logic [LW-1:0]     cnt, cnt_nxt;
  logic              unit_full, unit_full_nxt;
  logic [DATA_W-1:0] unit_q;
  logic              fifo_full, fifo_empty;
  logic              wr_fifo, rd_fifo, wr_unit, rd_unit;

  assign fifo_full  = (cnt == LW'(DEPTH));
  assign fifo_empty = (cnt == '0);
  assign wr_fifo = push && seq_mode && !fifo_full;
  assign rd_fifo = pop && seq_mode && !fifo_empty;
  assign wr_unit = push && !seq_mode && !unit_full;
  assign rd_unit = pop && !seq_mode && unit_full;

  always_comb begin
    cnt_nxt = cnt;
    if (wr_fifo && !rd_fifo) cnt_nxt = cnt + 1'b1;
    else if (rd_fifo && !wr_fifo) cnt_nxt = cnt - 1'b1;
    unit_full_nxt = unit_full;
    if (wr_unit) unit_full_nxt = 1'b1;
    else if (rd_unit) unit_full_nxt = 1'b0;
  end

  always_comb begin
    evt.lvl_hit = wr_unit ||
                  (wr_fifo && !rd_fifo &&
                   (cnt_nxt == LW'(THRESH) || cnt_nxt == LW'(DEPTH)));
    evt.fin_hit = wr_unit ||
                  (wr_fifo && !rd_fifo && cnt_nxt == LW'(DEPTH));
    evt.ovr_hit = push && (seq_mode ? fifo_full : unit_full);
  end

  // Queue storage: plain write port, no reset, so it maps to block RAM.
  always_ff @(posedge clk) begin
    if (wr_fifo) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_fifo) begin
      rd_data <= mem[rptr];
    end else if (rd_unit) begin
      rd_data <= unit_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr      <= '0;
      rptr      <= '0;
      cnt       <= '0;
      unit_full <= 1'b0;
      unit_q    <= '0;
      level     <= '0;
    end else begin
      if (wr_fifo) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (rd_fifo) rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      if (wr_unit) unit_q <= din;
      cnt       <= cnt_nxt;
      unit_full <= unit_full_nxt;
      level     <= seq_mode ? cnt_nxt : LW'(unit_full_nxt);
    end
  end
endmodule

// File: rtl/spi_rx_irq.sv
module spi_rx_irq
  import spi_rx_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  rx_evt_t       evt,
  input  logic          clr_wr,
  input  logic [ST_W-1:0] clr_mask,
  input  logic          lvl_ie,
  input  logic          fin_ie,
  output logic [ST_W-1:0] status,
  output logic          irq
);
  logic [ST_W-1:0] set_v;
  logic [ST_W-1:0] clr_v;

  assign set_v = {evt.ovr_hit, evt.fin_hit, evt.lvl_hit};
  assign clr_v = clr_wr ? clr_mask : '0;

  for (genvar i = 0; i < ST_W; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst) status[i] <= 1'b0;
      else     status[i] <= set_v[i] | (status[i] & ~clr_v[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= (status[ST_LVL] & lvl_ie) | (status[ST_FIN] & fin_ie);
  end
endmodule

// File: rtl/spi_rx_ctrl.sv
module spi_rx_ctrl
  import spi_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 32,
  parameter int THRESH = 16,
  localparam int LW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_en,
  input  logic              bit_ce,
  input  logic              sdi,
  input  logic              seq_mode,
  input  logic              rd_pop,
  output logic [DATA_W-1:0] rd_data,
  output logic [LW-1:0]     fifo_level,
  input  logic              clr_wr,
  input  logic [2:0]        clr_mask,
  input  logic              lvl_ie,
  input  logic              fin_ie,
  output logic [2:0]        status,
  output logic              rx_irq
);
  logic              byte_vld;
  logic [DATA_W-1:0] byte_q;
  rx_evt_t           evt;

  spi_rx_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .rx_en(rx_en), .bit_ce(bit_ce), .sdi(sdi),
    .byte_vld(byte_vld), .byte_q(byte_q)
  );

  spi_rx_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .THRESH(THRESH)) u_store (
    .clk(clk), .rst(rst), .seq_mode(seq_mode), .push(byte_vld), .din(byte_q),
    .pop(rd_pop), .rd_data(rd_data), .level(fifo_level), .evt(evt)
  );

  spi_rx_irq u_irq (
    .clk(clk), .rst(rst), .evt(evt), .clr_wr(clr_wr), .clr_mask(clr_mask),
    .lvl_ie(lvl_ie), .fin_ie(fin_ie), .status(status), .irq(rx_irq)
  );
endmodule

// File: rtl/spi_rx_ctrl_chk.sv
module spi_rx_ctrl_chk #(
  parameter int DEPTH = 32,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          seq_mode,
  input logic [LW-1:0] fifo_level,
  input logic          clr_wr,
  input logic [2:0]    clr_mask,
  input logic          lvl_ie,
  input logic          fin_ie,
  input logic [2:0]    status,
  input logic          rx_irq
);
  p_level_bound_r3: assert property (@(posedge clk) disable iff (rst)
    fifo_level <= LW'(DEPTH));

  p_unit_level_r2: assert property (@(posedge clk) disable iff (rst)
    $past(!seq_mode) |-> fifo_level <= LW'(1));

  p_fin_full_r5: assert property (@(posedge clk) disable iff (rst)
    ($rose(status[1]) && $past(seq_mode)) |-> fifo_level == LW'(DEPTH));

  p_sticky_ovr_r7: assert property (@(posedge clk) disable iff (rst)
    ($past(status[2]) && !$past(clr_wr && clr_mask[2])) |-> status[2]);

  p_irq_src_r8: assert property (@(posedge clk) disable iff (rst)
    rx_irq |-> $past((status[0] && lvl_ie) || (status[1] && fin_ie)));

  p_step_r3: assert property (@(posedge clk) disable iff (rst)
    ($past(seq_mode) && seq_mode && $past(fifo_level) > 0 && $past(fifo_level) < LW'(DEPTH))
      |-> (fifo_level <= $past(fifo_level) + 1'b1 && fifo_level + 1'b1 >= $past(fifo_level)));
endmodule

bind spi_rx_ctrl spi_rx_ctrl_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .seq_mode(seq_mode), .fifo_level(fifo_level),
  .clr_wr(clr_wr), .clr_mask(clr_mask), .lvl_ie(lvl_ie), .fin_ie(fin_ie),
  .status(status), .rx_irq(rx_irq)
);

// File: tb/spi_rx_ctrl_bench.sv
`timescale 1ns/1ps
module spi_rx_ctrl_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_en = 1'b0, bit_ce = 1'b0, sdi = 1'b0, seq_mode = 1'b0, rd_pop = 1'b0;
  logic clr_wr = 1'b0, lvl_ie = 1'b0, fin_ie = 1'b0;
  logic [2:0] clr_mask = 3'b000;
  logic [7:0] rd_data;
  logic [5:0] fifo_level;
  logic [2:0] status;
  logic rx_irq;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit cmp_on = 1'b0;

  always #2.5 clk = ~clk;

  spi_rx_ctrl u_spi_rx_ctrl (
    .clk(clk), .rst(rst), .rx_en(rx_en), .bit_ce(bit_ce), .sdi(sdi),
    .seq_mode(seq_mode), .rd_pop(rd_pop), .rd_data(rd_data),
    .fifo_level(fifo_level), .clr_wr(clr_wr), .clr_mask(clr_mask),
    .lvl_ie(lvl_ie), .fin_ie(fin_ie), .status(status), .rx_irq(rx_irq)
  );

  // Behavioural reference model, advanced once per rising edge.
  int       m_bits;
  int       m_sh;
  bit       m_bv;
  int       m_bval;
  int       q[$];
  bit       m_ufull;
  int       m_unit;
  int       m_rd;
  bit [2:0] m_st;
  bit       m_irq;
  int       m_lvl;

  always @(posedge clk) begin
    bit [2:0] st_old, setv;
    bit popped;
    if (rst) begin
      m_bits = 0; m_sh = 0; m_bv = 0; m_bval = 0; q.delete();
      m_ufull = 0; m_unit = 0; m_rd = 0; m_st = 0; m_irq = 0; m_lvl = 0;
    end else begin
      st_old = m_st;
      setv = 3'b000;
      popped = 0;
      m_irq = (st_old[0] && lvl_ie) || (st_old[1] && fin_ie);
      if (seq_mode) begin
        bit was_full;
        was_full = (q.size() == 32);
        if (rd_pop && q.size() > 0) begin m_rd = q.pop_front(); popped = 1; end
        if (m_bv) begin
          if (was_full) setv[2] = 1;
          else begin
            q.push_back(m_bval);
            if (!popped && (q.size() == 16 || q.size() == 32)) setv[0] = 1;
            if (!popped && q.size() == 32) setv[1] = 1;
          end
        end
        m_lvl = q.size();
      end else begin
        bit was_full;
        was_full = m_ufull;
        if (rd_pop && m_ufull) begin m_rd = m_unit; m_ufull = 0; end
        if (m_bv) begin
          if (was_full) setv[2] = 1;
          else begin m_unit = m_bval; m_ufull = 1; setv[1:0] = 2'b11; end
        end
        m_lvl = m_ufull ? 1 : 0;
      end
      for (int i = 0; i < 3; i++)
        m_st[i] = setv[i] | (st_old[i] & !(clr_wr && clr_mask[i]));
      m_bv = 0;
      if (!rx_en) m_bits = 0;
      else if (bit_ce) begin
        m_sh = ((m_sh << 1) | int'(sdi)) & 8'hFF;
        if (m_bits == 7) begin m_bits = 0; m_bv = 1; m_bval = m_sh; end
        else m_bits++;
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Per-cycle comparison against the model, away from the active edge.
  always @(negedge clk) begin
    if (cmp_on) begin
      check("R3 rd_data", int'(rd_data), m_rd);
      check("R3 fifo_level", int'(fifo_level), m_lvl);
      check("R7 status", int'(status), int'(m_st));
      check("R8 rx_irq", int'(rx_irq), int'(m_irq));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected below 100000 cycles", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send_bits(input logic [7:0] b, input int nb);
    for (int i = 7; i > 7 - nb; i--) begin
      @(negedge clk); sdi = b[i]; bit_ce = 1'b1;
      @(negedge clk); bit_ce = 1'b0;
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    send_bits(b, 8);
    idle(2);
  endtask

  task automatic pop();
    @(negedge clk); rd_pop = 1'b1;
    @(negedge clk); rd_pop = 1'b0;
  endtask

  task automatic clear(input logic [2:0] m);
    @(negedge clk); clr_wr = 1'b1; clr_mask = m;
    @(negedge clk); clr_wr = 1'b0; clr_mask = 3'b000;
    idle(1);
  endtask

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    cmp_on = 1'b1;
    // R10 reset state
    check("R10 rd_data", int'(rd_data), 0);
    check("R10 fifo_level", int'(fifo_level), 0);
    check("R10 status", int'(status), 0);
    check("R10 rx_irq", int'(rx_irq), 0);

    // R2 unit mode: both requests together
    rx_en = 1'b1; lvl_ie = 1'b1; fin_ie = 1'b1;
    send_byte(8'hA5);
    check("R2 level", int'(fifo_level), 1);
    check("R2 status", int'(status), 3);
    check("R8 irq", int'(rx_irq), 1);
    pop(); idle(1);
    check("R1 msb first", int'(rd_data), 8'hA5);
    check("R3 unit empty", int'(fifo_level), 0);
    clear(3'b111);
    check("R7 clear", int'(status), 0);
    idle(1);
    check("R8 irq drops", int'(rx_irq), 0);

    // R6 unit overrun
    send_byte(8'h11);
    send_byte(8'h22);
    check("R6 unit ovr", int'(status[2]), 1);
    check("R6 unit level", int'(fifo_level), 1);
    pop(); idle(1);
    check("R6 kept first", int'(rd_data), 8'h11);
    // R9 pop while empty
    pop(); idle(1);
    check("R9 rd_data held", int'(rd_data), 8'h11);
    check("R9 level held", int'(fifo_level), 0);
    // R7 partial clear and stickiness
    clear(3'b011);
    check("R7 ovr sticky", int'(status), 4);
    clear(3'b100);

    // R1 partial byte dropped on rx_en low
    send_bits(8'hF0, 4);
    @(negedge clk); rx_en = 1'b0;
    @(negedge clk); rx_en = 1'b1;
    send_byte(8'h3C);
    pop(); idle(1);
    check("R1 restart", int'(rd_data), 8'h3C);
    clear(3'b111);

    // Sequential mode fill
    seq_mode = 1'b1; lvl_ie = 1'b0; fin_ie = 1'b1;
    idle(1);
    for (int k = 0; k < 15; k++) send_byte(8'(8'h40 + k));
    check("R4 no lvl at 15", int'(status[0]), 0);
    send_byte(8'h4F);
    check("R4 lvl at 16", int'(status[0]), 1);
    check("R5 no fin at 16", int'(status[1]), 0);
    idle(1);
    check("R8 lvl masked", int'(rx_irq), 0);
    clear(3'b001);
    for (int k = 16; k < 31; k++) send_byte(8'(8'h40 + k));
    check("R4 no lvl at 31", int'(status[0]), 0);
    check("R5 no fin at 31", int'(status[1]), 0);
    send_byte(8'h5F);
    check("R5 fin at 32", int'(status[1]), 1);
    check("R4 lvl at 32", int'(status[0]), 1);
    check("R3 full level", int'(fifo_level), 32);
    idle(1);
    check("R8 fin irq", int'(rx_irq), 1);
    send_byte(8'hEE);
    check("R6 seq ovr", int'(status[2]), 1);
    check("R6 seq level", int'(fifo_level), 32);
    for (int k = 0; k < 32; k++) begin
      pop(); idle(1);
      check("R3 order", int'(rd_data), 8'h40 + k);
    end
    check("R3 drained", int'(fifo_level), 0);
    pop(); idle(1);
    check("R9 seq empty pop", int'(rd_data), 8'h5F);
    clear(3'b111);
    idle(3);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule